// File: doc/BRIEF.md
# Clock Ratio and Prescaler Control Unit

This block is a byte-addressed control unit for a clock generator. Software writes multiplier M and N values and then starts a ratio load. A status flag marks that a clock change is in progress while the new ratio settles, and a lock bit reports when settling is done. The multiplier is not built. Its settling is modelled by a counter of configurable length.

The same register space holds packed prescaler fields. From these fields the block makes seven synchronous clock-enable strobes, all derived from one source clock. A core strobe divides the source clock. The AHB-side, flash-interface and I3C strobes divide the core strobe further. The three peripheral-bus strobes divide the undivided source clock. Every field holds the divide ratio minus one.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: After reset every mapped register reads 0, control bits 7 (change) and 2 (lock) are clear, and all seven enable outputs are high in every cycle.
- R2: Byte registers decode at fixed offsets. Offset 0x002 holds M low, 0x004 holds M high, 0x006 holds N, and 0x01D is a plain byte; all four read back all 8 written bits. Offset 0x008 reads back fully, with the core field in [7:4] and the AHB-side field in [3:0]. Offset 0x010 reads back fully, with peripheral bus 1 in [3:0] and bus 2 in [7:4]. Offset 0x012 keeps only [1:0] (flash interface) and [3:2] (I3C). Offset 0x014 keeps only [3:0] (peripheral bus 3). Bits that are not kept read 0.
- R3: A write to offset 0x000 with bit 0 set clears lock and sets control bit 7 from the next cycle on. Bit 7 then stays set for exactly SETTLE_CYCLES cycles. In the cycle it clears, bit 2 (lock) becomes set.
- R4: The load bit (bit 0 of offset 0x000) reads 1 in the single cycle after the load write and 0 from then on.
- R5: Writing M, N, or offset 0x000 with bit 0 clear leaves bits 7 and 2 of offset 0x000 unchanged.
- R6: The core enable pulses once every (core field + 1) source cycles. Each peripheral-bus enable pulses once every (its field + 1) source cycles, whatever the core field is.
- R7: The AHB-side, flash-interface and I3C enables pulse only in cycles where the core enable is high. Each one pulses once every (core field + 1) × (its field + 1) source cycles.
- R8: A divider field written in the middle of a count takes effect at the next terminal count. The interval already running ends at the old ratio, and the following interval uses the new ratio.
- R9: Writes to reserved or unmapped offsets change no register, and those offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRdata | output | 8 | Read data for busAddr, combinational |
| coreEn | output | 1 | Core clock enable |
| ahbEn | output | 1 | AHB-side clock enable (divides core) |
| fiuEn | output | 1 | Flash-interface clock enable (divides core) |
| i3cEn | output | 1 | I3C clock enable (divides core) |
| apb1En | output | 1 | Peripheral bus 1 clock enable |
| apb2En | output | 1 | Peripheral bus 2 clock enable |
| apb3En | output | 1 | Peripheral bus 3 clock enable |

## Verification
The hardest case to reach is a divider field rewritten in the middle of a count. Only the lengths of the next two intervals show whether the old ratio finished and the new one took over. The stimulus waits for an enable pulse, then writes the new field in that same cycle. It then measures the gap to the next pulse and the gap after that. For the cascaded enables, a steady-state gap only appears once both the core counter and the child counter have reloaded. Each measurement therefore throws away the first two intervals after a configuration change.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int DIV_W    = 4;
  localparam int NARROW_W = 2;
  localparam int NUM_SUB  = 3;  // 0: AHB side, 1: flash interface, 2: I3C
  localparam int NUM_APB  = 3;

  localparam int OFS_CTRL  = 'h000;
  localparam int OFS_MLO   = 'h002;
  localparam int OFS_MHI   = 'h004;
  localparam int OFS_NVAL  = 'h006;
  localparam int OFS_PRESC = 'h008;
  localparam int OFS_BDIV0 = 'h010;
  localparam int OFS_BDIV1 = 'h012;
  localparam int OFS_BDIV2 = 'h014;
  localparam int OFS_BDIV3 = 'h01D;

  localparam int BIT_LOAD = 0;
  localparam int BIT_LOCK = 2;
  localparam int BIT_CHG  = 7;

  typedef struct packed {
    logic [DIV_W-1:0]              coreRatio;
    logic [NUM_SUB-1:0][DIV_W-1:0] subRatio;
    logic [NUM_APB-1:0][DIV_W-1:0] apbRatio;
  } divCfg_t;
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
#(
  parameter int ADDR_W        = 9,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busWe,
  output logic [7:0]        busRdata,
  output divCfg_t           divCfg
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic selCtrl, selMlo, selMhi, selN, selPresc, selB0, selB1, selB2, selB3;
  assign selCtrl  = (busAddr == ADDR_W'(OFS_CTRL));
  assign selMlo   = (busAddr == ADDR_W'(OFS_MLO));
  assign selMhi   = (busAddr == ADDR_W'(OFS_MHI));
  assign selN     = (busAddr == ADDR_W'(OFS_NVAL));
  assign selPresc = (busAddr == ADDR_W'(OFS_PRESC));
  assign selB0    = (busAddr == ADDR_W'(OFS_BDIV0));
  assign selB1    = (busAddr == ADDR_W'(OFS_BDIV1));
  assign selB2    = (busAddr == ADDR_W'(OFS_BDIV2));
  assign selB3    = (busAddr == ADDR_W'(OFS_BDIV3));

  logic [7:0]          mLo, mHi, nVal, prescReg, busDiv0, spareByte;
  logic [NARROW_W-1:0] fiuRatio, i3cRatio;
  logic [DIV_W-1:0]    apb3Ratio;
  logic                loadPend, chgFlag, lockBit;
  logic [CNT_W-1:0]    settleCnt;
  logic                loadWr;

  assign loadWr = busWe && selCtrl && busWdata[BIT_LOAD];

  // Plain configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mLo <= '0; mHi <= '0; nVal <= '0; prescReg <= '0;
      busDiv0 <= '0; spareByte <= '0;
      fiuRatio <= '0; i3cRatio <= '0; apb3Ratio <= '0;
    end else if (busWe) begin
      if (selMlo)   mLo       <= busWdata;
      if (selMhi)   mHi       <= busWdata;
      if (selN)     nVal      <= busWdata;
      if (selPresc) prescReg  <= busWdata;
      if (selB0)    busDiv0   <= busWdata;
      if (selB3)    spareByte <= busWdata;
      if (selB1) begin
        fiuRatio <= busWdata[NARROW_W-1:0];
        i3cRatio <= busWdata[2*NARROW_W-1:NARROW_W];
      end
      if (selB2)    apb3Ratio <= busWdata[DIV_W-1:0];
    end
  end

  // Ratio load handshake with settle counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadPend  <= 1'b0;
      chgFlag   <= 1'b0;
      lockBit   <= 1'b0;
      settleCnt <= '0;
    end else begin
      loadPend <= loadWr;
      if (loadWr) begin
        chgFlag   <= 1'b1;
        lockBit   <= 1'b0;
        settleCnt <= CNT_W'(SETTLE_CYCLES - 1);
      end else if (chgFlag) begin
        if (settleCnt == '0) begin
          chgFlag <= 1'b0;
          lockBit <= 1'b1;
        end else begin
          settleCnt <= settleCnt - 1'b1;
        end
      end
    end
  end

  logic [7:0] ctrlView;
  always_comb begin
    ctrlView           = '0;
    ctrlView[BIT_LOAD] = loadPend;
    ctrlView[BIT_LOCK] = lockBit;
    ctrlView[BIT_CHG]  = chgFlag;
  end

  always_comb begin
    busRdata = '0;
    if (selCtrl)  busRdata = ctrlView;
    if (selMlo)   busRdata = mLo;
    if (selMhi)   busRdata = mHi;
    if (selN)     busRdata = nVal;
    if (selPresc) busRdata = prescReg;
    if (selB0)    busRdata = busDiv0;
    if (selB1)    busRdata = 8'({i3cRatio, fiuRatio});
    if (selB2)    busRdata = 8'(apb3Ratio);
    if (selB3)    busRdata = spareByte;
  end

  always_comb begin
    divCfg.coreRatio   = prescReg[7:4];
    divCfg.subRatio[0] = prescReg[3:0];
    divCfg.subRatio[1] = DIV_W'(fiuRatio);
    divCfg.subRatio[2] = DIV_W'(i3cRatio);
    divCfg.apbRatio[0] = busDiv0[3:0];
    divCfg.apbRatio[1] = busDiv0[7:4];
    divCfg.apbRatio[2] = apb3Ratio;
  end

  p_chg_on_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    loadWr |=> (chgFlag && !lockBit));
  p_lock_on_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chgFlag) |-> lockBit);
  p_load_selfclr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (loadPend && !loadWr) |=> !loadPend);
  p_status_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!loadWr && !chgFlag) |=> (!chgFlag && $stable(lockBit)));
endmodule

// File: rtl/clkgen_divcell.sv
module clkgen_divcell #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         srcEn,
  input  logic [W-1:0] ratio,
  output logic         tick
);
  logic [W-1:0] cnt;

  // The count restarts from the live field only at a terminal count,
  // so an interval in progress always completes at its old length.
  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (srcEn) cnt <= (cnt == '0) ? ratio : cnt - 1'b1;
  end

  assign tick = srcEn && (cnt == '0);
endmodule

// File: rtl/clkgen_divs.sv
module clkgen_divs
  import clkgen_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  divCfg_t            divCfg,
  output logic               coreEn,
  output logic [NUM_SUB-1:0] subEn,
  output logic [NUM_APB-1:0] apbEn
);
  clkgen_divcell #(.W(DIV_W)) coreDiv_i (
    .clk(clk), .rstN(rstN), .srcEn(1'b1),
    .ratio(divCfg.coreRatio), .tick(coreEn)
  );

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    clkgen_divcell #(.W(DIV_W)) subDiv_i (
      .clk(clk), .rstN(rstN), .srcEn(coreEn),
      .ratio(divCfg.subRatio[g]), .tick(subEn[g])
    );
    p_sub_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
      subEn[g] |-> coreEn);
  end

  for (genvar g = 0; g < NUM_APB; g++) begin : g_apb
    clkgen_divcell #(.W(DIV_W)) apbDiv_i (
      .clk(clk), .rstN(rstN), .srcEn(1'b1),
      .ratio(divCfg.apbRatio[g]), .tick(apbEn[g])
    );
  end
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clkgen_pkg::*;
#(
  parameter int ADDR_W        = 9,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busWe,
  output logic [7:0]        busRdata,
  output logic              coreEn,
  output logic              ahbEn,
  output logic              fiuEn,
  output logic              i3cEn,
  output logic              apb1En,
  output logic              apb2En,
  output logic              apb3En
);
  divCfg_t            divCfg;
  logic [NUM_SUB-1:0] subEn;
  logic [NUM_APB-1:0] apbEn;

  clkgen_regs #(.ADDR_W(ADDR_W), .SETTLE_CYCLES(SETTLE_CYCLES)) regs_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .divCfg(divCfg)
  );

  clkgen_divs divs_i (
    .clk(clk), .rstN(rstN), .divCfg(divCfg),
    .coreEn(coreEn), .subEn(subEn), .apbEn(apbEn)
  );

  assign ahbEn  = subEn[0];
  assign fiuEn  = subEn[1];
  assign i3cEn  = subEn[2];
  assign apb1En = apbEn[0];
  assign apb2En = apbEn[1];
  assign apb3En = apbEn[2];
endmodule

// File: tb/clk_ratio_ctrl_tb_top.sv
module clk_ratio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 20;
  localparam int AW         = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [7:0]    busWdata = '0;
  logic          busWe = 1'b0;
  logic [7:0]    busRdata;
  logic coreEn, ahbEn, fiuEn, i3cEn, apb1En, apb2En, apb3En;
  logic [6:0] ens;
  assign ens = {apb3En, apb2En, apb1En, i3cEn, fiuEn, ahbEn, coreEn};

  int testsRun = 0;
  int testsFailed = 0;
  bit summaryDone = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_ratio_ctrl #(.ADDR_W(AW), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .coreEn(coreEn), .ahbEn(ahbEn),
    .fiuEn(fiuEn), .i3cEn(i3cEn), .apb1En(apb1En), .apb2En(apb2En),
    .apb3En(apb3En)
  );

  // Vector table: prescaler, bus div 0/1/2, then expected periods in
  // the order core, ahb, fiu, i3c, apb1, apb2, apb3.
  localparam int NV = 4;
  localparam logic [7:0] V_PRESC [NV] = '{8'h21, 8'h00, 8'hF3, 8'h4F};
  localparam logic [7:0] V_BD0   [NV] = '{8'h53, 8'hF0, 8'h0A, 8'h77};
  localparam logic [7:0] V_BD1   [NV] = '{8'h0E, 8'h01, 8'h04, 8'h0F};
  localparam logic [7:0] V_BD2   [NV] = '{8'h07, 8'h0F, 8'h02, 8'h00};
  localparam int V_EXP [NV][7] = '{
    '{3, 6, 9, 12, 4, 6, 8},
    '{1, 1, 2, 1, 1, 16, 16},
    '{16, 64, 16, 32, 11, 1, 3},
    '{5, 80, 20, 20, 8, 8, 1}
  };

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic busWrite(input int addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = AW'(addr); busWdata = data; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input int addr, output logic [7:0] data);
    busAddr = AW'(addr);
    #1 data = busRdata;
  endtask

  task automatic measureGap(input int idx, output int gap);
    int guard = 0;
    int n;
    @(negedge clk);
    while (!ens[idx] && guard < 4000) begin @(negedge clk); guard++; end
    gap = 0;
    for (int k = 0; k < 3; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!ens[idx] && n < 4000);
      gap = n;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!summaryDone) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int gap, hiCnt;
    int regOfs [9] = '{'h000, 'h002, 'h004, 'h006, 'h008, 'h010, 'h012, 'h014, 'h01D};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 9; i++) begin
      busRead(regOfs[i], rd);
      check("R1 reset register value", int'(rd), 0);
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 all enables high every cycle after reset", int'(ens), 'h7F);
    end

    // R2: readback and field masking
    busWrite('h002, 8'hEC); busWrite('h004, 8'h0B); busWrite('h006, 8'h82);
    busWrite('h01D, 8'hA5); busWrite('h012, 8'hFF); busWrite('h014, 8'hFF);
    busWrite('h008, 8'h5A); busWrite('h010, 8'h3C);
    busRead('h002, rd); check("R2 M low readback", int'(rd), 'hEC);
    busRead('h004, rd); check("R2 M high readback", int'(rd), 'h0B);
    busRead('h006, rd); check("R2 N readback", int'(rd), 'h82);
    busRead('h01D, rd); check("R2 byte at 0x01D readback", int'(rd), 'hA5);
    busRead('h012, rd); check("R2 0x012 keeps bits 3:0 only", int'(rd), 'h0F);
    busRead('h014, rd); check("R2 0x014 keeps bits 3:0 only", int'(rd), 'h0F);
    busRead('h008, rd); check("R2 prescaler readback", int'(rd), 'h5A);
    busRead('h010, rd); check("R2 bus divider 0 readback", int'(rd), 'h3C);

    // R5: M/N and control writes without load leave status alone
    busWrite('h000, 8'h84);
    busRead('h000, rd); check("R5 control write without load bit", int'(rd), 0);
    busWrite('h006, 8'h02);
    busRead('h000, rd); check("R5 N write without load", int'(rd), 0);

    // R3 / R4: load handshake
    busWrite('h000, 8'h01);
    busRead('h000, rd); check("R4 load bit visible one cycle (ctrl 0x81)", int'(rd), 'h81);
    hiCnt = 1;
    @(negedge clk);
    busRead('h000, rd); check("R4 load bit self-cleared (ctrl 0x80)", int'(rd), 'h80);
    while (rd[7] && hiCnt < 1000) begin
      hiCnt++;
      @(negedge clk);
      busRead('h000, rd);
    end
    check("R3 change flag high for SETTLE cycles", hiCnt, SETTLE);
    check("R3 lock set when change flag clears", int'(rd), 'h04);

    // R5: after lock, M/N writes do not disturb lock
    busWrite('h002, 8'h72); busWrite('h004, 8'h09);
    busWrite('h000, 8'h00);
    busRead('h000, rd); check("R5 lock stays after M writes", int'(rd), 'h04);

    // R9: reserved and unmapped offsets
    busWrite('h001, 8'hFF); busWrite('h003, 8'hFF); busWrite('h00A, 8'hFF);
    busWrite('h01C, 8'hFF); busWrite('h100, 8'hFF);
    busRead('h001, rd); check("R9 reserved 0x001 reads 0", int'(rd), 0);
    busRead('h00A, rd); check("R9 reserved 0x00A reads 0", int'(rd), 0);
    busRead('h01C, rd); check("R9 reserved 0x01C reads 0", int'(rd), 0);
    busRead('h100, rd); check("R9 unmapped 0x100 reads 0", int'(rd), 0);
    busRead('h002, rd); check("R9 M low unchanged", int'(rd), 'h72);
    busRead('h000, rd); check("R9 control unchanged", int'(rd), 'h04);
    busRead('h008, rd); check("R9 prescaler unchanged", int'(rd), 'h5A);

    // R6 / R7: divider vector table
    for (int v = 0; v < NV; v++) begin
      busWrite('h008, V_PRESC[v]); busWrite('h010, V_BD0[v]);
      busWrite('h012, V_BD1[v]);   busWrite('h014, V_BD2[v]);
      for (int s = 0; s < 7; s++) begin
        measureGap(s, gap);
        if (s == 0 || s >= 4)
          check($sformatf("R6 vector %0d enable %0d period", v, s), gap, V_EXP[v][s]);
        else
          check($sformatf("R7 vector %0d enable %0d period", v, s), gap, V_EXP[v][s]);
      end
    end

    // R7: cascaded enables never pulse without the core enable
    busWrite('h008, 8'h21); busWrite('h012, 8'h00);
    hiCnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if ((ahbEn || fiuEn || i3cEn) && !coreEn) hiCnt++;
    end
    check("R7 cascaded pulse outside core enable", hiCnt, 0);

    // R8: field rewrite mid-interval
    busWrite('h010, 8'h07);
    measureGap(4, gap);
    check("R8 initial apb1 period", gap, 8);
    @(negedge clk);
    while (!apb1En) @(negedge clk);
    busAddr = AW'('h010); busWdata = 8'h01; busWe = 1'b1;
    gap = 0;
    do begin @(negedge clk); busWe = 1'b0; gap++; end while (!apb1En && gap < 100);
    check("R8 running interval ends at old ratio", gap, 8);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!apb1En && gap < 100);
    check("R8 next interval uses new ratio", gap, 2);

    summaryDone = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule